// File: doc/BRIEF.md
# Global Interrupt Enable Gate

This block sits between the per-source interrupt request lines and the interrupt-accept logic of an instruction sequencer. It holds one global enable flag and one register of individual mask bits. A request reaches the sequencer only when its source is unmasked and the global flag is set. Single-cycle command pulses clear or set the global flag. Clearing it hides every user interrupt, the power-down source included, and leaves the individual mask bits unchanged. The next enable command therefore restores exactly the set of sources that were unmasked before.

Autobuffer service requests take a separate path that the global flag never touches. Data transfers keep running while interrupts are disabled. Raw requests are not stored or cleared here. A request that is still held when the flag comes back is serviced without being raised again. Vectoring, priority selection and the return stack belong to the sequencer.

Top module: `irq_global_gate`

## Requirements
- R1: After reset the global flag (`gie_o`) is 1 and every mask bit (`mask_o`) is 0, so every source starts masked.
- R2: A disable pulse clears `gie_o` at the next rising clock edge. While `gie_o` is 0, `irq_o` is all zeros whatever the raw requests and the mask hold.
- R3: The mask register keeps its contents across disable and enable pulses. It changes only on a mask write.
- R4: An enable pulse without a disable pulse sets `gie_o` at the next rising clock edge.
- R5: When enable and disable pulses arrive in the same cycle, `gie_o` is 0 after that edge.
- R6: Bit i of `irq_o` is 1 exactly when raw request bit i, mask bit i and `gie_o` are all 1. This holds combinationally in the current cycle.
- R7: The power-down source (bit `PD_IDX`, bit 9 by default) obeys the global flag like every other source. It is blocked while `gie_o` is 0 and passes while the flag is set and its mask bit is 1.
- R8: `ab_o` equals `ab_req_i` in every cycle, whether `gie_o` is 0 or 1.
- R9: When `mask_we_i` is 1 at a rising edge, `mask_o` takes the value of `mask_wdata_i`. This works whether the global flag is set or cleared.
- R10: A raw request held through a disabled period appears on `irq_o` in the first cycle after an enable pulse sets the flag. It does not have to be raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SRC | Raw interrupt requests, one bit per source |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | N_SRC | Value to load into the mask register; 1 means unmasked |
| ena_pulse_i | input | 1 | Global enable command, one cycle wide |
| dis_pulse_i | input | 1 | Global disable command, one cycle wide |
| ab_req_i | input | N_AB | Autobuffer service requests |
| irq_o | output | N_SRC | Gated requests to the sequencer |
| mask_o | output | N_SRC | Current mask register contents |
| gie_o | output | 1 | Current global enable flag |
| ab_o | output | N_AB | Autobuffer requests, passed through ungated |

## Verification
The bench builds the block with its default parameters: ten sources, the power-down source on bit 9 and four autobuffer lines. At this width the power-down bit is the top bit of the request vector. A mask such as 0x0F0 can then shut out the top bit while letting a middle group through. Four autobuffer lines let the bench show that distinct patterns pass unchanged through disabled periods. The vector table walks mask writes made while the flag is cleared, simultaneous enable and disable pulses, and requests held across a disabled window. Directed steps then cover the reset state at power-up and after a reset in mid-run.

// File: rtl/irq_global_gate.sv
module irq_global_gate #(
  parameter int N_SRC  = 10,
  parameter int PD_IDX = 9,
  parameter int N_AB   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_i,
  input  logic             mask_we_i,
  input  logic [N_SRC-1:0] mask_wdata_i,
  input  logic             ena_pulse_i,
  input  logic             dis_pulse_i,
  input  logic [N_AB-1:0]  ab_req_i,
  output logic [N_SRC-1:0] irq_o,
  output logic [N_SRC-1:0] mask_o,
  output logic             gie_o,
  output logic [N_AB-1:0]  ab_o
);

  logic             gie_q;
  logic [N_SRC-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           gie_q <= 1'b1;
    else if (dis_pulse_i) gie_q <= 1'b0;
    else if (ena_pulse_i) gie_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  assign irq_o  = req_i & mask_q & {N_SRC{gie_q}};
  assign mask_o = mask_q;
  assign gie_o  = gie_q;
  assign ab_o   = ab_req_i;

  AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dis_pulse_i |=> !gie_o); // R2
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_o |-> (irq_o == '0)); // R2
  AST_MASK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we_i |=> $stable(mask_o)); // R3
  AST_ENA_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_pulse_i && !dis_pulse_i) |=> gie_o); // R4
  AST_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_pulse_i && dis_pulse_i) |=> !gie_o); // R5
  AST_GATE_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~(req_i & mask_o)) == '0)); // R6
  AST_PD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_o |-> !irq_o[PD_IDX]); // R7
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we_i |=> (mask_o == $past(mask_wdata_i))); // R9

endmodule

// File: tb/irq_global_gate_bench.sv
`timescale 1ns/1ps
module irq_global_gate_bench;
  localparam int NS = 10;
  localparam int NA = 4;
  localparam int NV = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] req = '0;
  logic          we = 1'b0;
  logic [NS-1:0] wdata = '0;
  logic          ena = 1'b0;
  logic          dis = 1'b0;
  logic [NA-1:0] ab = '0;
  logic [NS-1:0] irq, mask;
  logic          gie;
  logic [NA-1:0] ab_out;

  int applied = 0;
  int miss = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_global_gate #(.N_SRC(NS), .PD_IDX(9), .N_AB(NA)) u_irq_global_gate (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mask_we_i(we), .mask_wdata_i(wdata),
    .ena_pulse_i(ena), .dis_pulse_i(dis), .ab_req_i(ab),
    .irq_o(irq), .mask_o(mask), .gie_o(gie), .ab_o(ab_out));

  // one entry per vector, index k
  localparam logic [NV-1:0] T_ENA = 10'b00_0111_0000; // v4,v5,v6
  localparam logic [NV-1:0] T_DIS = 10'b01_0010_0100; // v2,v5,v8
  localparam logic [NV-1:0] T_WE  = 10'b00_1000_1001; // v0,v3,v7
  localparam logic [NS-1:0] T_WD  [NV] = '{10'h3FF, 10'h000, 10'h000, 10'h0F0, 10'h000,
                                           10'h000, 10'h000, 10'h201, 10'h000, 10'h000};
  localparam logic [NS-1:0] T_REQ [NV] = '{10'h000, 10'h205, 10'h205, 10'h3FF, 10'h3FF,
                                           10'h3FF, 10'h201, 10'h201, 10'h201, 10'h201};
  localparam logic [NA-1:0] T_AB  [NV] = '{4'h0, 4'h5, 4'hA, 4'h0, 4'h6,
                                           4'hF, 4'h0, 4'h9, 4'h3, 4'hC};
  localparam logic [NV-1:0] E_GIE = 10'b00_1101_0011;
  localparam logic [NS-1:0] E_IRQ [NV] = '{10'h000, 10'h205, 10'h000, 10'h000, 10'h0F0,
                                           10'h000, 10'h000, 10'h201, 10'h000, 10'h000};
  localparam logic [NS-1:0] E_MSK [NV] = '{10'h3FF, 10'h3FF, 10'h3FF, 10'h0F0, 10'h0F0,
                                           10'h0F0, 10'h0F0, 10'h201, 10'h201, 10'h201};
  localparam string E_TAG [NV] = '{"R9", "R6", "R2 R3 R7 R8", "R9 R3", "R4 R10",
                                   "R5 R8", "R6", "R7 R9", "R2 R8", "R2"};

  task automatic check(input string tag, input logic [NS-1:0] act, input logic [NS-1:0] exp);
    applied++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: got %h, want %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", applied, miss);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miss++;
      $display("FAIL watchdog: got hang, want completion");
      summary();
    end
  end

  initial begin
    req = 10'h3FF; ab = 4'h7;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 gie", {9'd0, gie}, 10'd1);
    check("R1 mask", mask, 10'h000);
    check("R1 irq", irq, 10'h000);
    check("R8 ab", {6'd0, ab_out}, {6'd0, 4'h7});
    rst_n = 1'b1;
    req = '0; ab = '0;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      ena = T_ENA[k]; dis = T_DIS[k]; we = T_WE[k];
      wdata = T_WD[k]; req = T_REQ[k]; ab = T_AB[k];
      @(posedge clk);
      #1;
      applied++;
      if (irq !== E_IRQ[k] || gie !== E_GIE[k] || mask !== E_MSK[k] || ab_out !== T_AB[k]) begin
        miss++;
        $display("FAIL %s vec %0d: got irq=%h gie=%b mask=%h ab=%h, want irq=%h gie=%b mask=%h ab=%h",
                 E_TAG[k], k, irq, gie, mask, ab_out, E_IRQ[k], E_GIE[k], E_MSK[k], T_AB[k]);
      end
    end

    @(negedge clk);
    ena = 0; dis = 0; we = 0;
    // R6: same cycle, no edge needed; mask 0x201 while disabled gives zero
    req = 10'h001;
    #0.5;
    check("R2 comb off", irq, 10'h000);

    // R4 R10: enable, held request appears, pd bit passes
    ena = 1; req = 10'h201;
    @(posedge clk); #1;
    ena = 0;
    check("R10 reappear", irq, 10'h201);
    // R6: dropping a raw request removes it in the same cycle
    @(negedge clk);
    req = 10'h200;
    #0.5;
    check("R6 comb", irq, 10'h200);

    // R1: reset in mid-run returns to enabled, all masked
    @(negedge clk);
    dis = 1;
    @(negedge clk);
    dis = 0;
    check("R2 off", {9'd0, gie}, 10'd0);
    rst_n = 0;
    #0.5;
    check("R1 gie mid", {9'd0, gie}, 10'd1);
    check("R1 mask mid", mask, 10'h000);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 irq mid", irq, 10'h000);

    done = 1;
    summary();
  end
endmodule